// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog that asks for a system reset when software stops servicing it. A prescaler divides the input clock. Its ticks drive a down-counter that restarts from a programmable reload value. When the count runs out, the block raises a one-cycle reset request and starts the next period on its own. Software services the watchdog with a kick, which restarts the period.

The block has four control registers: kick, reload value, run control and prescale. Each one sits behind its own lock register. A lock opens only after a fixed series of key words is written to it in order, and it then accepts exactly one write to the register it guards. Any write that breaks the series closes the lock again. Software can read each lock's two-bit progress to confirm every step. The run control lock needs three keys; the other locks need two. Stray bus traffic therefore cannot stop, retune or service the watchdog by accident.

The register interface is a plain 32-bit bus. It has a write strobe, a 3-bit word address, write data, and read data that follows the address combinationally.

Top module: `keyguard_wdog`

## Requirements
- R1: After reset the watchdog is stopped. Every lock reads 00, prescale reads 0, reload reads 0xFFFF, the kick word reads 0 and the reset request is low.
- R2: Word address map: 0 kick lock, 1 kick, 2 reload lock, 3 reload, 4 run lock, 5 run control, 6 prescale lock, 7 prescale. A lock register reads its progress in bits 1:0, with all other bits zero. The kick lock takes 0x5555 then 0xAAAA, the reload lock takes 0x6666 then 0xBBBB, and the prescale lock takes 0x5A5A then 0xA5A5. Each of these locks reads 01 after its first key and 11 after its second.
- R3: The run lock takes 0x7777, then 0xCCCC, then 0xDDDD, and reads 01, 10 and 11 after the three steps.
- R4: A lock write whose full 32-bit word differs from the next expected key returns that lock to 00. A key given out of order also returns the lock to 00.
- R5: A write to a guarded register whose lock is not at 11 leaves that register unchanged and returns its lock to 00.
- R6: An accepted write to a guarded register returns its lock to 00, so a second write without a new unlock is ignored.
- R7: Writing bit 0 = 1 to the run control while it is stopped starts the watchdog. Starting loads the counter from reload value N and clears the prescaler. With prescale P, the first reset request appears N*(P+1) clocks after the starting write.
- R8: The reset request is high for one clock at each expiry. The counter then reloads, so requests repeat every N*(P+1) clocks.
- R9: An accepted kick write with bit 0 = 1 reloads the counter and clears the prescaler, so the next request comes N*(P+1) clocks after the kick. An accepted kick write with bit 0 = 0 leaves the timing unchanged.
- R10: Writing bit 0 = 0 to the run control stops the watchdog. While stopped, no reset request is raised.
- R11: Reading back gives reload in bits 15:0, prescale in its low bits, and the run state in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wdog_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with its default 16-bit counter and 16-bit prescale widths. It programs small reload and prescale values, such as N=4 with P=2 and N=20 with P=0, so that several full periods, kicks and expiries fit into a few hundred clocks. Because the widths are the defaults, the reset reload of 0xFFFF is checked by reading it back rather than by waiting for it to run out.

// File: rtl/kgw_pkg.sv
package kgw_pkg;

  // word addresses on the register bus
  localparam logic [2:0] A_KICK_LK = 3'd0;
  localparam logic [2:0] A_KICK    = 3'd1;
  localparam logic [2:0] A_RELD_LK = 3'd2;
  localparam logic [2:0] A_RELD    = 3'd3;
  localparam logic [2:0] A_RUN_LK  = 3'd4;
  localparam logic [2:0] A_RUN     = 3'd5;
  localparam logic [2:0] A_PRE_LK  = 3'd6;
  localparam logic [2:0] A_PRE     = 3'd7;

  localparam int NUM_LOCKS = 4;

  // number of keys each lock needs (lock 2 guards run control)
  function automatic int keys_needed(input int lk);
    return (lk == 2) ? 3 : 2;
  endfunction

  // key word k of lock lk
  function automatic logic [15:0] key_word(input int lk, input int k);
    logic [15:0] r;
    r = 16'h0000;
    case (lk)
      0: r = (k == 0) ? 16'h5555 : 16'hAAAA;
      1: r = (k == 0) ? 16'h6666 : 16'hBBBB;
      2: r = (k == 0) ? 16'h7777 : ((k == 1) ? 16'hCCCC : 16'hDDDD);
      default: r = (k == 0) ? 16'h5A5A : 16'hA5A5;
    endcase
    return r;
  endfunction

  // lock progress code: two-key locks skip code 10
  function automatic logic [1:0] step_code(input logic [1:0] step, input int nkeys);
    if (nkeys == 2 && step == 2'd2) return 2'b11;
    return step;
  endfunction

  // counter next value on a tick: returns reload at expiry
  function automatic logic [31:0] count_next(input logic [31:0] cur, input logic [31:0] reld);
    return (cur <= 32'd1) ? reld : cur - 32'd1;
  endfunction

endpackage

// File: rtl/kgw_lock.sv
module kgw_lock #(
  parameter int          NKEYS = 2,
  parameter logic [15:0] KEY0  = 16'h0000,
  parameter logic [15:0] KEY1  = 16'h0000,
  parameter logic [15:0] KEY2  = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        guard_wr,
  output logic        unlocked,
  output logic [1:0]  status
);
  localparam logic [1:0] LAST = 2'(NKEYS);

  logic [1:0]  step_q;
  logic [15:0] want;
  logic        key_ok;

  always_comb begin
    if (step_q == 2'd0 || step_q >= LAST) want = KEY0;
    else if (step_q == 2'd1)              want = KEY1;
    else                                  want = KEY2;
  end

  assign key_ok   = (key_data == {16'h0000, want});
  assign unlocked = (step_q == LAST);
  assign status   = kgw_pkg::step_code(step_q, NKEYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step_q <= 2'd0;
    else if (guard_wr) step_q <= 2'd0;
    else if (key_wr) begin
      if (!key_ok)              step_q <= 2'd0;
      else if (step_q == LAST)  step_q <= 2'd1;
      else                      step_q <= step_q + 2'd1;
    end
  end
endmodule

// File: rtl/kgw_prescale.sv
module kgw_prescale #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q;

  assign tick = run && !clear && (pcnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt_q <= '0;
    else if (clear) pcnt_q <= '0;
    else if (run)   pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/kgw_counter.sv
module kgw_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reld,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign count  = cnt_q;
  assign expire = tick && !load && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '1;
    else if (load)  cnt_q <= reld;
    else if (tick)  cnt_q <= CNT_W'(kgw_pkg::count_next(32'(cnt_q), 32'(reld)));
  end
endmodule

// File: rtl/keyguard_wdog.sv
module keyguard_wdog #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdog_rst_req
);
  import kgw_pkg::*;

  localparam int NL = NUM_LOCKS;

  logic [NL-1:0] key_wr, guard_wr, unlocked, accept;
  logic [1:0]    lk_status [NL];

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lock
      assign key_wr[g]   = bus_wr && (bus_addr == 3'(2 * g));
      assign guard_wr[g] = bus_wr && (bus_addr == 3'(2 * g + 1));
      assign accept[g]   = guard_wr[g] && unlocked[g];
      kgw_lock #(
        .NKEYS (keys_needed(g)),
        .KEY0  (key_word(g, 0)),
        .KEY1  (key_word(g, 1)),
        .KEY2  (key_word(g, 2))
      ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr[g]),
        .key_data (bus_wdata),
        .guard_wr (guard_wr[g]),
        .unlocked (unlocked[g]),
        .status   (lk_status[g])
      );
    end
  endgenerate

  // named events for the checker
  logic [1:0] kick_status, run_status;
  logic       kick_accept, kick_go, run_set, run_rise, reld_set, pre_set;
  logic       cnt_load, tick, expire;

  assign kick_status = lk_status[0];
  assign run_status  = lk_status[2];
  assign kick_accept = accept[0];
  assign kick_go     = accept[0] && bus_wdata[0];
  assign reld_set    = accept[1];
  assign run_set     = accept[2];
  assign pre_set     = accept[3];

  logic             en_q;
  logic [CNT_W-1:0] reload_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_val;

  assign run_rise = run_set && bus_wdata[0] && !en_q;
  assign cnt_load = kick_go || run_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      reload_q <= '1;
      pre_q    <= '0;
    end else begin
      if (run_set)  en_q     <= bus_wdata[0];
      if (reld_set) reload_q <= bus_wdata[CNT_W-1:0];
      if (pre_set)  pre_q    <= bus_wdata[PRE_W-1:0];
    end
  end

  kgw_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .clear (cnt_load),
    .div   (pre_q),
    .tick  (tick)
  );

  kgw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cnt_load),
    .tick   (tick),
    .reld   (reload_q),
    .count  (cnt_val),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_rst_req <= 1'b0;
    else        wdog_rst_req <= expire;
  end

  always_comb begin
    bus_rdata = 32'h0;
    case (bus_addr)
      A_KICK_LK, A_RELD_LK, A_RUN_LK, A_PRE_LK:
        bus_rdata = {30'h0, lk_status[bus_addr[2:1]]};
      A_RELD:  bus_rdata = 32'(reload_q);
      A_RUN:   bus_rdata = {31'h0, en_q};
      A_PRE:   bus_rdata = 32'(pre_q);
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/kgw_chk.sv
module kgw_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             cnt_load,
  input logic             kick_accept,
  input logic [1:0]       kick_status,
  input logic [1:0]       run_status,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] reload_q,
  input logic             wdog_rst_req
);
  // R10
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> $past(en_q));

  // R6
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_accept |=> (kick_status == 2'b00));

  // R2
  kick_no_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_status != 2'b10);

  // R3
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_status == 2'b11) |-> ($past(run_status) == 2'b10));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_load) |=> $stable(cnt_val));

  // R7
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (cnt_val == reload_q));
endmodule

bind keyguard_wdog kgw_chk #(.CNT_W(CNT_W)) u_kgw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_q         (en_q),
  .cnt_load     (cnt_load),
  .kick_accept  (kick_accept),
  .kick_status  (kick_status),
  .run_status   (run_status),
  .cnt_val      (cnt_val),
  .reload_q     (reload_q),
  .wdog_rst_req (wdog_rst_req)
);

// File: tb/keyguard_wdog_bench.sv
module keyguard_wdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_req;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  cyc     = 0;
  bit  summary_done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  logic rd_v = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyguard_wdog u_keyguard_wdog (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .wdog_rst_req (wdog_rst_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read items and compares
  always @(posedge clk) begin
    #1;
    if (rd_v && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes expected value, monitor compares
  task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a; rd_v = 1'b1;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic set_run(bit on);
    wr(3'd4, 32'h7777); wr(3'd4, 32'hCCCC); wr(3'd4, 32'hDDDD);
    wr(3'd5, {31'h0, on});
  endtask

  task automatic set_reload(logic [31:0] v);
    wr(3'd2, 32'h6666); wr(3'd2, 32'hBBBB); wr(3'd3, v);
  endtask

  task automatic set_pre(logic [31:0] v);
    wr(3'd6, 32'h5A5A); wr(3'd6, 32'hA5A5); wr(3'd7, v);
  endtask

  task automatic kick(bit val);
    wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); wr(3'd1, {31'h0, val});
  endtask

  // expects the request exactly when cyc-mark == n, low elsewhere up to n+1
  task automatic wait_pulse(int mark, int n, string tag);
    int early;
    early = 0;
    while (cyc - mark <= n) begin
      if (cyc - mark < n && wdog_rst_req) early++;
      if (cyc - mark == n) check({tag, " pulse"}, {31'h0, wdog_rst_req}, 32'h1);
      @(negedge clk);
    end
    check({tag, " pulse width"}, {31'h0, wdog_rst_req}, 32'h0);
    check({tag, " no early pulse"}, early, 0);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int mark;
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req low", {31'h0, wdog_rst_req}, 32'h0);
    rd(3'd0, 32'h0, "R1 kick lock");
    rd(3'd2, 32'h0, "R1 reload lock");
    rd(3'd4, 32'h0, "R1 run lock");
    rd(3'd6, 32'h0, "R1 prescale lock");
    rd(3'd3, 32'hFFFF, "R1 reload");
    rd(3'd7, 32'h0, "R1 prescale");
    rd(3'd5, 32'h0, "R1 stopped");
    rd(3'd1, 32'h0, "R1 kick reads 0");

    // R5 locked write ignored
    wr(3'd3, 32'h33);
    rd(3'd3, 32'hFFFF, "R5 locked reload write");
    wr(3'd2, 32'h6666);
    rd(3'd2, 32'h1, "R2 reload lock step1");
    wr(3'd3, 32'h44);
    rd(3'd2, 32'h0, "R5 lock cleared by locked write");
    rd(3'd3, 32'hFFFF, "R5 reload unchanged");

    // R4 wrong key, full-word compare, order
    wr(3'd2, 32'h6666); wr(3'd2, 32'h1234);
    rd(3'd2, 32'h0, "R4 wrong second key");
    wr(3'd0, 32'h10005555);
    rd(3'd0, 32'h0, "R4 upper bits set");
    wr(3'd4, 32'hCCCC);
    rd(3'd4, 32'h0, "R4 out of order");

    // R2 progressions
    wr(3'd0, 32'h5555); rd(3'd0, 32'h1, "R2 kick step1");
    wr(3'd0, 32'hAAAA); rd(3'd0, 32'h3, "R2 kick step2");
    wr(3'd6, 32'h5A5A); rd(3'd6, 32'h1, "R2 prescale step1");
    wr(3'd6, 32'hA5A5); rd(3'd6, 32'h3, "R2 prescale step2");
    wr(3'd7, 32'h2);
    rd(3'd7, 32'h2, "R11 prescale readback");
    rd(3'd6, 32'h0, "R6 prescale lock cleared");

    // R3 three-key progression
    wr(3'd4, 32'h7777); rd(3'd4, 32'h1, "R3 run step1");
    wr(3'd4, 32'hCCCC); rd(3'd4, 32'h2, "R3 run step2");
    wr(3'd4, 32'hDDDD); rd(3'd4, 32'h3, "R3 run step3");
    wr(3'd4, 32'h0);    rd(3'd4, 32'h0, "R4 wrong key after open");

    // R6 one write per unlock
    set_reload(32'h4);
    wr(3'd3, 32'h99);
    rd(3'd3, 32'h4, "R6 second write ignored");

    // R7/R8 start with N=4 P=2 -> 12 clocks
    set_run(1'b1);
    mark = cyc;
    rd(3'd5, 32'h1, "R11 run readback");
    wait_pulse(mark, 12, "R7 first expiry");
    wait_pulse(mark, 24, "R8 periodic expiry");

    // R10 stop: no request
    set_run(1'b0);
    rd(3'd5, 32'h0, "R10 stopped readback");
    hits = 0;
    repeat (60) begin
      @(negedge clk);
      if (wdog_rst_req) hits++;
    end
    check("R10 no request while stopped", hits, 0);

    // R9 kick restarts: N=20 P=0
    set_reload(32'd20);
    rd(3'd3, 32'd20, "R11 reload readback");
    set_pre(32'h0);
    set_run(1'b1);
    kick(1'b1);
    mark = cyc;
    rd(3'd0, 32'h0, "R6 kick lock cleared");
    wait_pulse(mark, 20, "R9 kick restart");
    kick(1'b0);
    wait_pulse(mark, 40, "R9 kick zero no effect");

    set_run(1'b0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule